// File: doc/BRIEF.md
# Dual-Mode Programmable Clock Synthesizer

The block derives a programmable output clock from one of four source clocks. Each source reaches it as a one-cycle enable strobe in the single system clock domain. The outputs are a clock level and a one-cycle tick that marks each output period. Software writes a control word in one cycle. The word holds a 2-bit source select, a 14-bit frequency field, a mode bit and an active-high stop bit. The same field has two meanings, chosen by the mode bit. With mode 0 it is the step of a 14-bit phase accumulator, so the output frequency is source × field / 2^14. With mode 1 it is a terminal count, so the output frequency is source / (field + 1). A field of zero in mode 0 passes the source straight through.

A small state machine sequences the block. `ST_OFF` holds everything at zero while the stop bit is set. After any write that leaves the block running, `ST_ARMED` waits for the first event of the selected source and clears the counter on it. The machine then moves to one of three run states. `ST_BYPASS` is taken for mode 0 with a zero field, `ST_ACCUM` for mode 0 with a non-zero field, and `ST_DIVIDE` for mode 1. The transitions are: *write-stop* (any state to `ST_OFF`), *write-run* (any state to `ST_ARMED`), *first-event* (`ST_ARMED` to the run state the configuration picks), and *hold* (every other cycle). The reset value of the field is a parameter, so one design serves a general-purpose clock (reset 0) and a serial-port baud clock (reset 0x1BE).

Top module: `clksyn_top`

## Requirements
- R1: After reset, `clk_out` and `clk_tick` are 0. `cfg_rdata` reads {16'h0, select=2'b00, field=RESET_PHASE}. The block starts in `ST_BYPASS` if RESET_PHASE is 0 and in `ST_ACCUM` otherwise.
- R2: Only the strobe `src_evt[sel]` counts as a source event. Strobes on the other three inputs have no effect on `clk_out` or `clk_tick`. Source encoding: 0 = main crystal, 1 = PLL, 2 = secondary crystal, 3 = divided PLL.
- R3: In `ST_BYPASS`, each source event drives `clk_out`=1 and `clk_tick`=1 for the next cycle. A cycle with no event drives `clk_out`=0.
- R4: In `ST_ACCUM`, each source event adds the field to a 14-bit accumulator. `clk_out` is the accumulator's bit 13 and holds between events. `clk_tick` pulses when that bit goes from 0 to 1, which gives field/2^14 ticks per event.
- R5: In `ST_ACCUM`, field values above 0x2000 are clamped to a step of 0x2000, which gives exactly one tick per two events.
- R6: In `ST_DIVIDE`, a counter advances on each source event. On the event where it equals the field, it returns to 0 and drives `clk_out`=1 and `clk_tick`=1. Every other event drives `clk_out`=0. The result is one tick per field+1 events.
- R7: A write with the stop bit set enters `ST_OFF`. While in `ST_OFF`, `clk_out`, `clk_tick` and the counter are held at 0.
- R8: A write without the stop bit enters `ST_ARMED`. The first selected event after it clears the counter and drives `clk_out`=0 with no tick. Counting begins on the following event. Until that first event, `clk_out` holds its value.
- R9: `clk_tick` is high for exactly one cycle per output period, and only while `clk_out` is 1. The write cycle itself produces no tick.
- R10: `cfg_rdata` returns {16'h0, select[1:0], field[13:0]}. The field is read back raw, with no clamping, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 4 | One-cycle event strobes of the four sources |
| cfg_wr | input | 1 | Control write strobe |
| cfg_src | input | 2 | Source select to write |
| cfg_phase | input | 14 | Frequency field to write |
| cfg_div_mode | input | 1 | 0 = accumulator/bypass, 1 = integer divider |
| cfg_disable | input | 1 | 1 = stop the output clock |
| cfg_rdata | output | 32 | Read-back of select and field |
| clk_out | output | 1 | Generated clock level |
| clk_tick | output | 1 | One-cycle strobe, one per output period |

## Verification
The counter and the state register can only be seen through `clk_out` and `clk_tick`. The bench therefore keeps its own behavioural model and compares both outputs and the read-back on every cycle. A wrong counter value or wrong state usually shows up within one or two selected source events, as a misplaced level or tick. A wrong accumulator step shows up only over a longer span, as a drift in the tick rate. For that reason the bench also counts ticks over 1024 events and compares the count with the programmed ratio. A missed restart after a write shows up on the first event, as a tick where the model expects none.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_ARMED  = 3'd1,
        ST_BYPASS = 3'd2,
        ST_ACCUM  = 3'd3,
        ST_DIVIDE = 3'd4
    } syn_state_t;

endpackage

// File: rtl/clksyn_ctrl.sv
module clksyn_ctrl
    import clksyn_pkg::*;
#(
    parameter int PHASE_W     = 14,
    parameter int SEL_W       = 2,
    parameter int RESET_PHASE = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [SEL_W-1:0]   cfg_src,
    input  logic [PHASE_W-1:0] cfg_phase,
    input  logic               cfg_div_mode,
    input  logic               cfg_disable,
    input  logic               evt,
    output syn_state_t         state,
    output logic [SEL_W-1:0]   sel_q,
    output logic [PHASE_W-1:0] phase_q
);

    localparam syn_state_t RESET_STATE = (RESET_PHASE == 0) ? ST_BYPASS : ST_ACCUM;

    logic       mode_q;
    syn_state_t state_q, state_d;

    // control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            phase_q <= PHASE_W'(RESET_PHASE);
            mode_q  <= 1'b0;
        end else if (cfg_wr) begin
            sel_q   <= cfg_src;
            phase_q <= cfg_phase;
            mode_q  <= cfg_div_mode;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            state_d = cfg_disable ? ST_OFF : ST_ARMED;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_OFF;
                ST_ARMED: begin
                    if (evt) begin
                        if (mode_q)              state_d = ST_DIVIDE;
                        else if (phase_q == '0)  state_d = ST_BYPASS;
                        else                     state_d = ST_ACCUM;
                    end
                end
                ST_BYPASS: state_d = ST_BYPASS;
                ST_ACCUM:  state_d = ST_ACCUM;
                ST_DIVIDE: state_d = ST_DIVIDE;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    assign state = state_q;

    assert_stop_enters_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_disable) |=> (state_q == ST_OFF));

    assert_run_write_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_disable) |=> (state_q == ST_ARMED));

endmodule

// File: rtl/clksyn_core.sv
module clksyn_core
    import clksyn_pkg::*;
#(
    parameter int PHASE_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  syn_state_t         state,
    input  logic               evt,
    input  logic               cfg_wr,
    input  logic               cfg_disable,
    input  logic [PHASE_W-1:0] phase,
    output logic               clk_out,
    output logic               clk_tick
);

    localparam logic [PHASE_W-1:0] STEP_MAX = PHASE_W'(1) << (PHASE_W - 1);

    logic [PHASE_W-1:0] ph_q;
    logic [PHASE_W-1:0] step;
    logic [PHASE_W:0]   sum;

    assign step = (phase > STEP_MAX) ? STEP_MAX : phase;
    assign sum  = {1'b0, ph_q} + {1'b0, step};

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= '0;
            clk_out  <= 1'b0;
            clk_tick <= 1'b0;
        end else if (cfg_wr) begin
            clk_tick <= 1'b0;
            if (cfg_disable) begin
                ph_q    <= '0;
                clk_out <= 1'b0;
            end
        end else begin
            unique case (state)
                ST_OFF: begin
                    ph_q     <= '0;
                    clk_out  <= 1'b0;
                    clk_tick <= 1'b0;
                end
                ST_ARMED: begin
                    clk_tick <= 1'b0;
                    if (evt) begin
                        ph_q    <= '0;
                        clk_out <= 1'b0;
                    end
                end
                ST_BYPASS: begin
                    clk_out  <= evt;
                    clk_tick <= evt;
                end
                ST_ACCUM: begin
                    clk_tick <= evt & sum[PHASE_W-1] & ~ph_q[PHASE_W-1];
                    if (evt) begin
                        ph_q    <= sum[PHASE_W-1:0];
                        clk_out <= sum[PHASE_W-1];
                    end
                end
                ST_DIVIDE: begin
                    clk_tick <= 1'b0;
                    if (evt) begin
                        if (ph_q == phase) begin
                            ph_q     <= '0;
                            clk_out  <= 1'b1;
                            clk_tick <= 1'b1;
                        end else begin
                            ph_q    <= ph_q + 1'b1;
                            clk_out <= 1'b0;
                        end
                    end
                end
                default: clk_tick <= 1'b0;
            endcase
        end
    end

    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !cfg_wr) |=> (!clk_out && !clk_tick && ph_q == '0));

    assert_tick_with_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_tick |-> clk_out);

    assert_first_event_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && evt && !cfg_wr) |=> (ph_q == '0 && !clk_out && !clk_tick));

    assert_accum_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && !evt && !cfg_wr) |=> $stable(clk_out));

    assert_div_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIVIDE) |-> (ph_q <= phase));

endmodule

// File: rtl/clksyn_top.sv
module clksyn_top
    import clksyn_pkg::*;
#(
    parameter int PHASE_W     = 14,
    parameter int NUM_SRC     = 4,
    parameter int REG_W       = 32,
    parameter int RESET_PHASE = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_evt,
    input  logic                       cfg_wr,
    input  logic [$clog2(NUM_SRC)-1:0] cfg_src,
    input  logic [PHASE_W-1:0]         cfg_phase,
    input  logic                       cfg_div_mode,
    input  logic                       cfg_disable,
    output logic [REG_W-1:0]           cfg_rdata,
    output logic                       clk_out,
    output logic                       clk_tick
);

    localparam int SEL_W = $clog2(NUM_SRC);
    localparam int PAD_W = REG_W - SEL_W - PHASE_W;

    syn_state_t         state;
    logic [SEL_W-1:0]   sel_q;
    logic [PHASE_W-1:0] phase_q;
    logic               evt;

    assign evt       = src_evt[sel_q];
    assign cfg_rdata = {{PAD_W{1'b0}}, sel_q, phase_q};

    clksyn_ctrl #(
        .PHASE_W     (PHASE_W),
        .SEL_W       (SEL_W),
        .RESET_PHASE (RESET_PHASE)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_src      (cfg_src),
        .cfg_phase    (cfg_phase),
        .cfg_div_mode (cfg_div_mode),
        .cfg_disable  (cfg_disable),
        .evt          (evt),
        .state        (state),
        .sel_q        (sel_q),
        .phase_q      (phase_q)
    );

    clksyn_core #(
        .PHASE_W (PHASE_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .evt         (evt),
        .cfg_wr      (cfg_wr),
        .cfg_disable (cfg_disable),
        .phase       (phase_q),
        .clk_out     (clk_out),
        .clk_tick    (clk_tick)
    );

    assert_readback_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata[PHASE_W-1:0] == $past(cfg_phase)
                    && cfg_rdata[PHASE_W+SEL_W-1:PHASE_W] == $past(cfg_src)));

endmodule

// File: tb/clksyn_top_tb.sv
module clksyn_top_tb;

    localparam int RST_PH = 'h1BE;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_evt = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_src = '0;
    logic [13:0] cfg_phase = '0;
    logic        cfg_div_mode = 1'b0;
    logic        cfg_disable = 1'b0;
    logic [31:0] cfg_rdata;
    logic        clk_out;
    logic        clk_tick;

    always #5 clk = ~clk;

    clksyn_top #(.RESET_PHASE(RST_PH)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .cfg_wr(cfg_wr),
        .cfg_src(cfg_src), .cfg_phase(cfg_phase), .cfg_div_mode(cfg_div_mode),
        .cfg_disable(cfg_disable), .cfg_rdata(cfg_rdata),
        .clk_out(clk_out), .clk_tick(clk_tick)
    );

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    int    cyc = 0;
    int    tick_count = 0;

    // behavioural model: 0 = stopped, 1 = waiting for first event, 2 = running
    int m_sel = 0, m_val = RST_PH, m_mode = 0, m_phase_st = 2;
    int m_ph = 0, m_gen = 0, m_tick = 0;

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check_one(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", cur_req, what, cyc, act, exp);
        end
    endtask

    task automatic compare();
        check_one("clk_out", int'(clk_out), m_gen);
        check_one("clk_tick", int'(clk_tick), m_tick);
        check_one("cfg_rdata", int'(cfg_rdata), (m_sel << 14) | m_val);
    endtask

    task automatic model(logic [3:0] s, bit wr, int sel, int val, int mode, int dis);
        bit ev;
        int step, sum;
        ev = s[m_sel];
        if (wr) begin
            m_sel = sel; m_val = val; m_mode = mode; m_tick = 0;
            if (dis != 0) begin m_phase_st = 0; m_gen = 0; m_ph = 0; end
            else m_phase_st = 1;
        end else if (m_phase_st == 0) begin
            m_gen = 0; m_tick = 0; m_ph = 0;
        end else if (!ev) begin
            m_tick = 0;
            if (m_phase_st == 2 && m_mode == 0 && m_val == 0) m_gen = 0;
        end else if (m_phase_st == 1) begin
            m_ph = 0; m_gen = 0; m_tick = 0; m_phase_st = 2;
        end else if (m_mode == 0 && m_val == 0) begin
            m_gen = 1; m_tick = 1;
        end else if (m_mode == 0) begin
            step = (m_val > 'h2000) ? 'h2000 : m_val;
            sum = m_ph + step;
            m_tick = ((sum >> 13) & 1) & ~((m_ph >> 13) & 1);
            m_ph = sum & 'h3FFF;
            m_gen = (m_ph >> 13) & 1;
        end else begin
            if (m_ph == m_val) begin m_ph = 0; m_gen = 1; m_tick = 1; end
            else begin m_ph = m_ph + 1; m_gen = 0; m_tick = 0; end
        end
    endtask

    function automatic logic [3:0] pattern(int c);
        logic [3:0] s;
        s[0] = (c % 2) == 0;
        s[1] = (c % 3) == 0;
        s[2] = ($urandom % 4) == 0;
        s[3] = 1'b1;
        return s;
    endfunction

    task automatic step(logic [3:0] s, bit wr, int sel, int val, int mode, int dis);
        @(negedge clk);
        compare();
        tick_count += int'(clk_tick);
        cyc++;
        src_evt = s; cfg_wr = wr; cfg_src = 2'(sel); cfg_phase = 14'(val);
        cfg_div_mode = mode[0]; cfg_disable = dis[0];
        model(s, wr, sel, val, mode, dis);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step(pattern(cyc), 0, 0, 0, 0, 0);
    endtask

    task automatic run_mask(int n, logic [3:0] mask);
        for (int i = 0; i < n; i++) step(pattern(cyc) & mask, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(int sel, int val, int mode, int dis);
        step('0, 1, sel, val, mode, dis);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then the reset field drives the accumulator
        cur_req = "R1";
        step('0, 0, 0, 0, 0, 0);
        cur_req = "R4";
        run(400);

        // R2: select PLL source, other strobes must not matter
        cur_req = "R2";
        wr(1, 'h2000, 0, 0);
        run(300);
        run_mask(60, 4'b1101);

        // R3: bypass
        cur_req = "R3";
        wr(0, 0, 0, 0);
        run(120);

        // R5: clamp of illegal fields
        cur_req = "R5";
        wr(3, 'h3FFF, 0, 0);
        run(100);
        wr(2, 'h2001, 0, 0);
        run(200);

        // R6: divider
        cur_req = "R6";
        wr(2, 0, 1, 0);
        run(150);
        wr(0, 5, 1, 0);
        run(200);
        wr(3, 7, 1, 0);
        run(100);

        // R7: stop and restart
        cur_req = "R7";
        wr(3, 3, 1, 1);
        run(80);
        wr(3, 3, 1, 0);
        run(60);

        // R8: write while running, back-to-back writes
        cur_req = "R8";
        wr(3, 'h800, 0, 0);
        run(5);
        wr(1, 'h1234, 0, 0);
        wr(3, 'h0FFF, 0, 0);
        run(200);

        // R10: raw read-back of a clamped field
        cur_req = "R10";
        wr(2, 'h3ABC, 0, 0);
        run(20);

        // R9: tick rate over 1024 events, accumulator 1/4
        cur_req = "R9";
        wr(3, 'h1000, 0, 0);
        run(2);
        tick_count = 0;
        run(1024);
        checks++;
        if (tick_count < 255 || tick_count > 256) begin
            fails++;
            $display("FAIL R9 accum tick count: actual %0d expected 256", tick_count);
        end
        // R6 rate: divide by 5 over 500 events
        cur_req = "R6";
        wr(3, 4, 1, 0);
        run(2);
        tick_count = 0;
        run(500);
        checks++;
        if (tick_count < 99 || tick_count > 100) begin
            fails++;
            $display("FAIL R6 divider tick count: actual %0d expected 100", tick_count);
        end
        @(negedge clk);
        compare();
        report();
    end

endmodule